// File: doc/BRIEF.md
# Byte Shift SPI Master with Two-Stage Handshake

This block is a host-mapped SPI master that moves one byte per transfer through an 8-bit shift register. It serves two slave devices, and each has its own chip select. The host sees two 16-bit registers, selected by a one-bit address: a data register and a control/status register. The control word asserts the chip selects, picks the direction, and carries a start strobe. The status half of the same word reports two things: when the byte has been captured into the shifter ("loaded"), and when all eight bits have left it ("done").

A host transfers a byte in four steps. It sets the strobe together with the select and direction bits. It waits for loaded and then drops the strobe, keeping the select bits as they were. It then waits for done. A frame wider than a byte is sent as a series of byte handshakes, most significant byte first, and the chip select stays asserted between them. For a read, the host takes each received byte from the data register and assembles the word itself: it shifts the earlier bytes left by eight and ORs in the new byte. Serial data moves MSB first in SPI mode 0. SCLK idles low and is divided down from the system clock.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, both chip-select pins are high, SCLK is low, and both registers read as zero.
- R2: Address 0 is the data register. Writes keep bits [7:0], and bits [15:8] read as 0. Address 1 is control/status. Bits 0, 1, 2 and 4 read back as written. Bit 3 is done, bit 5 is loaded, and every other bit reads 0.
- R3: Control bit 0 drives cs_n_o[0] low and control bit 1 drives cs_n_o[1] low, from the cycle after the write. Writing the control register as zero releases both pins high.
- R4: When bit 4 (strobe) is written as 1 with bit 2 at 0 (write), the data byte goes out on MOSI MSB first with exactly 8 SCLK pulses. Each bit is stable on the rising edge.
- R5: The loaded flag (status bit 5) rises once the strobe is accepted. It falls after the host writes the strobe bit back to 0.
- R6: The done flag (status bit 3) is low while bits are shifting and high after the eighth bit. It is cleared when the next strobe is accepted.
- R7: With bit 2 at 1 (read), MISO is sampled on each SCLK rising edge, MSB first. MOSI stays low, and the received byte is readable at address 0 once done is set.
- R8: A write transfer leaves the data register holding the byte that was sent.
- R9: SCLK is low whenever no transfer is in progress. Successive rising edges are 2*HALF_DIV system clocks apart.
- R10: If the strobe is left at 1 after done, no second transfer starts.
- R11: Byte handshakes in sequence under one held chip select form longer frames: two writes send 16 bits MSB byte first, and two reads rebuild a 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Host write enable |
| addr_i | input | 1 | Register select: 0 data, 1 control/status |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data for addr_i (combinational) |
| sclk_o | output | 1 | SPI serial clock, mode 0 |
| mosi_o | output | 1 | Serial data to slaves |
| miso_i | input | 1 | Serial data from slaves |
| cs_n_o | output | 2 | Chip selects, active low, one per device |

## Verification
The bench builds the block with HALF_DIV = 3, while the default is 4. An odd divider makes the half-period counter wrap at a value that is not a power of two, and the check on rising-edge spacing (6 clocks) catches an off-by-one in that counter. A small divider also keeps each byte to about 48 clocks, so the bench can poll the handshake, hold the strobe high for a long idle window, and run 16-bit frames in both directions without coming near the cycle limit.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int REG_W      = 16;
  localparam int BIT_SEL_A  = 0;
  localparam int BIT_SEL_B  = 1;
  localparam int BIT_DIR    = 2;
  localparam int BIT_DONE   = 3;
  localparam int BIT_STROBE = 4;
  localparam int BIT_LOADED = 5;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              done_i,
  input  logic              loaded_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [1:0]        sel_o,
  output logic              dir_rd_o,
  output logic              strobe_o
);
  logic [DATA_W-1:0] data_q;
  logic [1:0]        sel_q;
  logic              dir_q, strobe_q;
  logic              wr_data, wr_ctrl;

  assign wr_data = we_i && (addr_i == REG_DATA);
  assign wr_ctrl = we_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (wr_data) begin
      data_q <= wdata_i[DATA_W-1:0];
    end else if (rx_valid_i) begin
      data_q <= rx_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      dir_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q    <= {wdata_i[BIT_SEL_B], wdata_i[BIT_SEL_A]};
      dir_q    <= wdata_i[BIT_DIR];
      strobe_q <= wdata_i[BIT_STROBE];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_DATA) begin
      rdata_o[DATA_W-1:0] = data_q;
    end else begin
      rdata_o[BIT_SEL_A]  = sel_q[0];
      rdata_o[BIT_SEL_B]  = sel_q[1];
      rdata_o[BIT_DIR]    = dir_q;
      rdata_o[BIT_DONE]   = done_i;
      rdata_o[BIT_STROBE] = strobe_q;
      rdata_o[BIT_LOADED] = loaded_i;
    end
  end

  logic unused_w;
  assign unused_w = ^{wdata_i[REG_W-1:DATA_W], wdata_i[BIT_DONE]};

  assign tx_byte_o = data_q;
  assign sel_o     = sel_q;
  assign dir_rd_o  = dir_q;
  assign strobe_o  = strobe_q;
endmodule

// File: rtl/spi_handshake.sv
module spi_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic busy_i,
  input  logic fin_i,
  output logic start_o,
  output logic loaded_o,
  output logic done_o
);
  logic loaded_q, done_q;

  // accept only a fresh strobe: loaded must have been cleared first
  assign start_o = strobe_i && !loaded_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (start_o)       loaded_q <= 1'b1;
      else if (!strobe_i) loaded_q <= 1'b0;
      if (start_o)       done_q <= 1'b0;
      else if (fin_i)    done_q <= 1'b1;
    end
  end

  assign loaded_o = loaded_q;
  assign done_o   = done_q;
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || cnt_q == CNT_MAX) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  logic              busy_q, sclk_q, rd_q, fin_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [BC_W-1:0]   bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      rd_q    <= 1'b0;
      fin_q   <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        sclk_q  <= 1'b0;
        rd_q    <= rd_i;
        tx_sh_q <= rd_i ? '0 : tx_byte_i;
        bit_q   <= '0;
      end else if (busy_q && tick_i) begin
        if (!sclk_q) begin
          sclk_q  <= 1'b1;
          rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign fin_o      = fin_q;
  assign rx_valid_o = fin_q && rd_q;
  assign rx_byte_o  = rx_sh_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = busy_q && tx_sh_q[DATA_W-1];
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_byte_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [1:0]  cs_n_o
);
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic [1:0]        sel;
  logic              dir_rd, ctrl_strobe;
  logic              start, eng_busy, eng_fin, rx_valid, tick;
  logic              loaded_flag, done_flag;

  spi_port_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .done_i(done_flag), .loaded_i(loaded_flag),
    .tx_byte_o(tx_byte), .sel_o(sel), .dir_rd_o(dir_rd), .strobe_o(ctrl_strobe)
  );

  spi_handshake u_hs (
    .clk_i, .rst_ni,
    .strobe_i(ctrl_strobe), .busy_i(eng_busy), .fin_i(eng_fin),
    .start_o(start), .loaded_o(loaded_flag), .done_o(done_flag)
  );

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i, .rst_ni, .en_i(eng_busy), .tick_o(tick)
  );

  spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .tick_i(tick), .rd_i(dir_rd), .tx_byte_i(tx_byte),
    .miso_i, .busy_o(eng_busy), .fin_o(eng_fin), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .sclk_o, .mosi_o
  );

  // register bits are active-high, pins active-low
  assign cs_n_o = ~sel;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk #(
  parameter int HALF_DIV = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic        addr_i,
  input logic [15:0] wdata_i,
  input logic [1:0]  cs_n_o,
  input logic        sclk_o,
  input logic        eng_busy,
  input logic        done_flag,
  input logic        loaded_flag,
  input logic        ctrl_strobe
);
  assert_cs_follows_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> (cs_n_o == ~$past(wdata_i[1:0])));

  assert_sclk_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> !sclk_o);

  assert_sclk_min_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((HALF_DIV > 1) && !$stable(sclk_o)) |=> $stable(sclk_o));

  assert_no_done_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> !done_flag);

  assert_loaded_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loaded_flag) |-> !ctrl_strobe);

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_flag && ctrl_strobe && !eng_busy) |=> !eng_busy);
endmodule

bind spi_byte_port spi_byte_port_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .cs_n_o(cs_n_o), .sclk_o(sclk_o), .eng_busy(eng_busy), .done_flag(done_flag),
  .loaded_flag(loaded_flag), .ctrl_strobe(ctrl_strobe)
);

// File: tb/spi_byte_port_bench.sv
`timescale 1ns/1ps
module spi_byte_port_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [1:0]  cs_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_byte_port #(.DATA_W(8), .HALF_DIV(HALF)) u_spi_byte_port (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  // slave model
  logic [15:0] mosi_cap = '0;
  int          rise_cnt = 0;
  realtime     last_rise = 0, rise_gap = 0;
  logic [7:0]  slave_sh = '0;

  always @(posedge sclk) begin
    mosi_cap  <= {mosi_cap[14:0], mosi};
    rise_cnt  <= rise_cnt + 1;
    rise_gap  <= $realtime - last_rise;
    last_rise <= $realtime;
  end

  always @(negedge sclk) begin
    slave_sh <= {slave_sh[6:0], 1'b0};
    miso     <= slave_sh[6];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_status(input int bitpos, input logic val, input string req);
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      host_rd(1'b1, s);
      if (s[bitpos] == val) return;
    end
    check(req, {31'b0, ~val}, {31'b0, val});
  endtask

  // one byte handshake; sel is the 2-bit select field, rd the direction bit
  task automatic xfer(input logic [1:0] sel, input logic rd, input logic [7:0] tx,
                      input logic [7:0] slave_byte, output logic [7:0] rx);
    logic [15:0] s;
    if (!rd) host_wr(1'b0, {8'h00, tx});
    slave_sh = slave_byte;
    miso     = slave_byte[7];
    host_wr(1'b1, {11'b0, 1'b1, 1'b0, rd, sel});
    wait_status(5, 1'b1, "R5 loaded rise");
    host_wr(1'b1, {13'b0, rd, sel});
    wait_status(5, 1'b0, "R5 loaded fall");
    wait_status(3, 1'b1, "R6 done rise");
    host_rd(1'b0, s);
    rx = s[7:0];
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 cs_n", {30'b0, cs_n}, 32'h3);
    check("R1 sclk", {31'b0, sclk}, 32'h0);
    host_rd(1'b1, d); check("R1 ctrl/status", {16'b0, d}, 32'h0);
    host_rd(1'b0, d); check("R1 data", {16'b0, d}, 32'h0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    host_wr(1'b0, 16'hA5C3);
    host_rd(1'b0, d); check("R2 data low byte only", {16'b0, d}, 32'h00C3);
    host_wr(1'b1, 16'hFFE7);
    host_rd(1'b1, d); check("R2 ctrl readback", {16'b0, d}, 32'h0007);
    check("R3 both selects", {30'b0, cs_n}, 32'h0);
    host_wr(1'b1, 16'h0001); check("R3 select A", {30'b0, cs_n}, 32'h2);
    host_wr(1'b1, 16'h0002); check("R3 select B", {30'b0, cs_n}, 32'h1);
    host_wr(1'b1, 16'h0000); check("R3 release", {30'b0, cs_n}, 32'h3);
  endtask

  task automatic t_write_byte;
    logic [7:0]  rx;
    logic [15:0] s;
    int r0;
    r0 = rise_cnt;
    xfer(2'b01, 1'b0, 8'h96, 8'hFF, rx);
    check("R4 mosi byte", {24'b0, mosi_cap[7:0]}, 32'h96);
    check("R4 eight pulses", rise_cnt - r0, 8);
    check("R3 cs held during write", {30'b0, cs_n}, 32'h2);
    check("R8 data kept", {24'b0, rx}, 32'h96);
    check("R9 rise spacing", int'(rise_gap * 10), 2 * HALF * 50);
    check("R9 sclk idle", {31'b0, sclk}, 32'h0);
    host_rd(1'b1, s);
    check("R6 done set", {31'b0, s[3]}, 32'h1);
  endtask

  task automatic t_done_clear;
    logic [15:0] s;
    host_wr(1'b0, 16'h005A);
    host_wr(1'b1, 16'h0011);
    wait_status(5, 1'b1, "R5 loaded second");
    host_rd(1'b1, s);
    check("R6 done cleared on accept", {31'b0, s[3]}, 32'h0);
    host_wr(1'b1, 16'h0001);
    wait_status(3, 1'b1, "R6 done second");
    check("R4 second byte", {24'b0, mosi_cap[7:0]}, 32'h5A);
  endtask

  task automatic t_read_byte;
    logic [7:0] rx;
    xfer(2'b10, 1'b1, 8'h00, 8'h3C, rx);
    check("R7 rx byte", {24'b0, rx}, 32'h3C);
    check("R7 mosi low", {24'b0, mosi_cap[7:0]}, 32'h00);
    check("R3 cs B during read", {30'b0, cs_n}, 32'h1);
  endtask

  task automatic t_hold_strobe;
    int r0;
    host_wr(1'b0, 16'h00C5);
    host_wr(1'b1, 16'h0011);
    wait_status(3, 1'b1, "R10 first done");
    r0 = rise_cnt;
    repeat (200) @(negedge clk);
    check("R10 no second transfer", rise_cnt - r0, 0);
    host_wr(1'b1, 16'h0001);
    wait_status(5, 1'b0, "R10 loaded fall");
  endtask

  task automatic t_frames;
    logic [7:0] hi, lo;
    logic [15:0] word;
    xfer(2'b01, 1'b0, 8'hBE, 8'h00, hi);
    xfer(2'b01, 1'b0, 8'hEF, 8'h00, lo);
    check("R11 16-bit write", {16'b0, mosi_cap}, 32'hBEEF);
    xfer(2'b01, 1'b1, 8'h00, 8'h12, hi);
    word = {8'h00, hi};
    xfer(2'b01, 1'b1, 8'h00, 8'h34, lo);
    word = (word << 8) | {8'h00, lo};
    check("R11 16-bit read", {16'b0, word}, 32'h1234);
    host_wr(1'b1, 16'h0000);
    check("R3 release after frame", {30'b0, cs_n}, 32'h3);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regs;
    t_write_byte;
    t_done_clear;
    t_read_byte;
    t_hold_strobe;
    t_frames;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule